// File: doc/BRIEF.md
# Subranging Delay-Code Generator

This block turns a wide digital delay request into the control wires of a two-bank switched-capacitor delay stage. A first-order delta-sigma truncator reduces the wide input word to the stage's 10-bit physical resolution. The bits it drops are carried into the next sample through an error register, so the average of the truncated codes follows the wide input with sub-LSB accuracy.

The truncated word is divided into an upper coarse field and a lower fine field. The fine bank is built with about twice the range of one coarse step. For that reason the fine field is multiplied by a programmable gain, so that a full fine sweep spans exactly one coarse step and there is no jump where the two banks meet. The scaled value is clamped to the fine bank's largest code. Each field is then expanded to a thermometer code, which keeps each bank's delay monotonic in its code. Both thermometer buses come from one register stage, so both banks switch on the same clock edge.

The block is clocked once per reference period and accepts a new request on every edge.

Top module: `dtc_code_gen`

## Requirements
- R1: While `rst` is high on a clock edge, both thermometer outputs and the internal truncation error become zero on that edge.
- R2: On each edge with `rst` low, the truncated code q is floor((din + e) / 16) and the stored error e becomes (din + e) mod 16. The outputs derived from q appear on that same edge, one register after `din` and `fine_gain` are sampled.
- R3: Both outputs are thermometer codes: bit i is 1 exactly when i is less than the encoded count.
- R4: The coarse output has 15 wires, and its count equals q[9:6].
- R5: The fine output has 127 wires. Its count equals floor(q[5:0] * fine_gain / 64), where `fine_gain` is unsigned with 6 fractional bits (64 means unity gain). A gain of zero gives an all-zero fine output.
- R6: When the scaled fine value exceeds 127, the fine count is clamped to 127 (all wires set).
- R7: When din + e exceeds 16383, q saturates to 1023, and e still takes the low four bits of the sum.
- R8: With a constant, non-saturating `din` and unity gain, the sum of q over any 16 consecutive cycles equals `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per reference period |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 14 | Wide delay request |
| fine_gain | input | 8 | Fine-path gain, 6 fractional bits |
| coarse_th | output | 15 | Coarse bank thermometer code |
| fine_th | output | 127 | Fine bank thermometer code |

## Verification
The bench builds the block with its default parameters: a 14-bit input, a 4/6 split of the 10-bit word, and an 8-bit gain with 6 fractional bits. These values make each case reachable in a short directed run. A constant input returns the truncation error to its starting value within 16 cycles, so the exact averaging of R8 can be observed. A 6-bit fine field at gains near 2.0 reaches both sides of the 127 clamp. An all-ones input drives the saturation path on consecutive cycles.

// File: rtl/dtcg_pkg.sv
package dtcg_pkg;
    localparam int DIN_W_D     = 14;
    localparam int Q_W_D       = 10;
    localparam int CRS_W_D     = 4;
    localparam int GAIN_W_D    = 8;
    localparam int GAIN_FRAC_D = 6;
    localparam int FBANK_W_D   = 7;

    typedef enum logic [0:0] {
        SUM_IN_RANGE = 1'b0,
        SUM_OVERFLOW = 1'b1
    } sum_state_e;

    typedef enum logic [0:0] {
        SCALE_PASS  = 1'b0,
        SCALE_CLAMP = 1'b1
    } scale_state_e;
endpackage

// File: rtl/dtcg_dsm1.sv
module dtcg_dsm1
    import dtcg_pkg::*;
#(
    parameter int IN_W = DIN_W_D,
    parameter int Q_W  = Q_W_D
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] din,
    output logic [Q_W-1:0]  q
);
    localparam int TR_W = IN_W - Q_W;

    logic [TR_W-1:0] err_q;
    logic [IN_W:0]   sum;
    sum_state_e      st;

    always_comb begin
        sum = {1'b0, din} + {{(Q_W + 1){1'b0}}, err_q};
        st  = sum[IN_W] ? SUM_OVERFLOW : SUM_IN_RANGE;
        q   = (st == SUM_OVERFLOW) ? {Q_W{1'b1}} : sum[IN_W-1:TR_W];
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= sum[TR_W-1:0];
    end

    // R1: error register cleared by reset
    p_err_reset_r1: assert property (@(posedge clk) rst |=> err_q == '0);
endmodule

// File: rtl/dtcg_fine_scale.sv
module dtcg_fine_scale
    import dtcg_pkg::*;
#(
    parameter int FIN_W     = Q_W_D - CRS_W_D,
    parameter int GAIN_W    = GAIN_W_D,
    parameter int GAIN_FRAC = GAIN_FRAC_D,
    parameter int FBANK_W   = FBANK_W_D
) (
    input  logic [FIN_W-1:0]   fin,
    input  logic [GAIN_W-1:0]  gain,
    output logic [FBANK_W-1:0] scaled
);
    localparam int PROD_W    = FIN_W + GAIN_W;
    localparam int FBANK_MAX = (1 << FBANK_W) - 1;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] shifted;
    scale_state_e      st;

    always_comb begin
        prod    = PROD_W'(fin) * PROD_W'(gain);
        shifted = prod >> GAIN_FRAC;
        st      = (shifted > PROD_W'(FBANK_MAX)) ? SCALE_CLAMP : SCALE_PASS;
        scaled  = (st == SCALE_CLAMP) ? FBANK_W'(FBANK_MAX) : shifted[FBANK_W-1:0];
    end

    // R5: a zero gain always yields a zero fine count
    always_comb begin
        p_zero_gain_r5: assert (gain != '0 || scaled == '0);
    end
endmodule

// File: rtl/dtcg_therm.sv
module dtcg_therm #(
    parameter int CODE_W = 4,
    parameter int WIRES  = (1 << CODE_W) - 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [WIRES-1:0]  th
);
    for (genvar i = 0; i < WIRES; i++) begin : g_wire
        assign th[i] = (code > CODE_W'(i));
    end
endmodule

// File: rtl/dtc_code_gen.sv
module dtc_code_gen
    import dtcg_pkg::*;
#(
    parameter int IN_W      = DIN_W_D,
    parameter int Q_W       = Q_W_D,
    parameter int CRS_W     = CRS_W_D,
    parameter int GAIN_W    = GAIN_W_D,
    parameter int GAIN_FRAC = GAIN_FRAC_D,
    parameter int FBANK_W   = FBANK_W_D
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [IN_W-1:0]               din,
    input  logic [GAIN_W-1:0]             fine_gain,
    output logic [(1 << CRS_W)-2:0]       coarse_th,
    output logic [(1 << FBANK_W)-2:0]     fine_th
);
    localparam int FIN_W     = Q_W - CRS_W;
    localparam int CRS_WIRES = (1 << CRS_W) - 1;
    localparam int FIN_WIRES = (1 << FBANK_W) - 1;

    logic [Q_W-1:0]       q_c;
    logic [FBANK_W-1:0]   fscaled;
    logic [CRS_WIRES-1:0] crs_th_c;
    logic [FIN_WIRES-1:0] fin_th_c;
    logic                 primed;

    dtcg_dsm1 #(.IN_W(IN_W), .Q_W(Q_W)) u_dsm (
        .clk(clk), .rst(rst), .din(din), .q(q_c)
    );

    dtcg_fine_scale #(
        .FIN_W(FIN_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .FBANK_W(FBANK_W)
    ) u_scale (
        .fin(q_c[FIN_W-1:0]), .gain(fine_gain), .scaled(fscaled)
    );

    dtcg_therm #(.CODE_W(CRS_W), .WIRES(CRS_WIRES)) u_crs_th (
        .code(q_c[Q_W-1:FIN_W]), .th(crs_th_c)
    );

    dtcg_therm #(.CODE_W(FBANK_W), .WIRES(FIN_WIRES)) u_fin_th (
        .code(fscaled), .th(fin_th_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_th <= '0;
            fine_th   <= '0;
            primed    <= 1'b0;
        end else begin
            coarse_th <= crs_th_c;
            fine_th   <= fin_th_c;
            primed    <= 1'b1;
        end
    end

    // R1: outputs cleared by reset
    p_out_reset_r1: assert property (@(posedge clk)
        rst |=> (coarse_th == '0 && fine_th == '0));

    // R3: both buses stay in thermometer form
    p_crs_therm_r3: assert property (@(posedge clk) disable iff (rst)
        (coarse_th & (coarse_th + 1'b1)) == '0);
    p_fin_therm_r3: assert property (@(posedge clk) disable iff (rst)
        (fine_th & (fine_th + 1'b1)) == '0);

    // R5: zero gain sampled on the previous edge gives an empty fine bank
    p_gain_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(fine_gain) == '0) |-> fine_th == '0);

    // R7: an all-ones request always fills the coarse bank
    p_sat_r7: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(din) == {IN_W{1'b1}}) |-> coarse_th == {CRS_WIRES{1'b1}});
endmodule

// File: tb/sim_dtc_code_gen.sv
module sim_dtc_code_gen;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [13:0]  din = '0;
    logic [7:0]   fine_gain = 8'd64;
    logic [14:0]  coarse_th;
    logic [126:0] fine_th;

    int n_checks = 0;
    int n_fail   = 0;
    int e_m      = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dtc_code_gen u0 (
        .clk(clk), .rst(rst), .din(din), .fine_gain(fine_gain),
        .coarse_th(coarse_th), .fine_th(fine_th)
    );

    function automatic logic [14:0] therm15(int n);
        logic [14:0] v;
        for (int i = 0; i < 15; i++) v[i] = (i < n);
        return v;
    endfunction

    function automatic logic [126:0] therm127(int n);
        logic [126:0] v;
        for (int i = 0; i < 127; i++) v[i] = (i < n);
        return v;
    endfunction

    function automatic int pop15(logic [14:0] v);
        int c = 0;
        for (int i = 0; i < 15; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic int pop127(logic [126:0] v);
        int c = 0;
        for (int i = 0; i < 127; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, design registers at posedge, check at next negedge.
    task automatic step(int x, int g, string req, output int q_out);
        int s, q, cc, fc;
        din = 14'(x);
        fine_gain = 8'(g);
        s = x + e_m;
        q = (s > 16383) ? 1023 : (s >> 4);
        e_m = s & 15;
        cc = q >> 6;
        fc = ((q & 63) * g) >> 6;
        if (fc > 127) fc = 127;
        @(negedge clk);
        check(coarse_th == therm15(cc), req, "coarse", pop15(coarse_th), cc);
        check(fine_th == therm127(fc), req, "fine", pop127(fine_th), fc);
        q_out = q;
    endtask

    task automatic t_reset;
        int q;
        rst = 1'b1;
        din = 14'h3FFF;
        @(negedge clk);
        @(negedge clk);
        check(coarse_th == '0, "R1", "coarse in reset", pop15(coarse_th), 0);
        check(fine_th == '0, "R1", "fine in reset", pop127(fine_th), 0);
        rst = 1'b0;
        e_m = 0;
        // error starts at zero: 8 then 8 gives q=0 then q=1 (R1, R2)
        step(8, 64, "R1", q);
        step(8, 64, "R2", q);
    endtask

    task automatic t_dc_average;
        int q, sum;
        for (int k = 0; k < 16; k++) step(16'h1235, 64, "R2", q);
        sum = 0;
        for (int k = 0; k < 16; k++) begin
            step(16'h1235, 64, "R8", q);
            sum += pop15(coarse_th) * 64 + pop127(fine_th);
        end
        check(sum == 16'h1235, "R8", "16-cycle sum", sum, 16'h1235);
    endtask

    task automatic t_patterns;
        int q;
        int xs[6] = '{0, 16, 1024, 5000, 9999, 16000};
        foreach (xs[i]) step(xs[i], 64, "R4", q);
        foreach (xs[i]) step(xs[i], 40, "R5", q);
        foreach (xs[i]) step(16383 - xs[i], 200, "R3", q);
    endtask

    task automatic t_clamp;
        int q;
        // fine field 63 (low 4 input bits 0 keep e constant once 0)
        rst = 1'b1; @(negedge clk); rst = 1'b0; e_m = 0;
        step(63 << 4, 129, "R6", q);   // 126, below clamp
        step(63 << 4, 130, "R6", q);   // 127, at clamp
        step(63 << 4, 255, "R6", q);   // 251 -> clamp 127
        check(fine_th == '1, "R6", "full fine bank", pop127(fine_th), 127);
        step(63 << 4, 0, "R5", q);
        check(fine_th == '0, "R5", "zero gain", pop127(fine_th), 0);
    endtask

    task automatic t_saturate;
        int q;
        for (int k = 0; k < 4; k++) step(16383, 64, "R7", q);
        check(coarse_th == '1, "R7", "coarse full", pop15(coarse_th), 15);
        step(16, 64, "R7", q);         // uses error left by saturation
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_dc_average();
        t_patterns();
        t_clamp();
        t_saturate();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule